// File: doc/BRIEF.md
# Segmented-Page Address Translator

This block converts a 20-bit logical address into a 20-bit physical address for a memory system that is organised in segments and pages. The logical address has three fields. The top 4 bits select a segment, the next 8 bits select a page within it, and the low 8 bits select a word within the page. The physical address is a 12-bit block number followed by the unchanged 8-bit word offset.

A translation walks two tables. The segment number picks a page-table base from a segment table. That base, added to the page number, picks a page-table entry. The entry holds a present flag, a 2-bit rights code and the block number. Before any walk, a small fully associative lookaside buffer is searched on the combined segment and page value. A hit answers at once. A completed walk of a present entry is written into the buffer. Every result also reports a page fault (entry not present) or a rights violation. Software loads both tables through a write-only programming port, and each such write clears the lookaside buffer.

Top module: `seg_page_xlate`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid is 0. Every page-table entry reads as not present, so any request is answered with rsp_fault=1.
- R2: For a present entry with sufficient rights, rsp_paddr = {block, word}. The block comes from page-table entry (segment base + page), and the word offset is copied unchanged. Example: with segment 6 based at 0x35 and entry 0x37 holding block 0x019, logical 0x6027E gives 0x0197E.
- R3: A request is accepted on a rising edge N where req_valid=1 and req_ready=1. On a buffer miss, req_ready is 0 after edges N and N+1, and rsp_valid is 1 for exactly one cycle after edge N+2.
- R4: A repeated request whose mapping is held in the buffer is answered after edge N, with the same result as the walk would give.
- R5: The buffer holds 4 entries. Only walks that find a present entry insert into it, and it replaces entries in round-robin order starting from entry 0.
- R6: Any write on the programming port empties the buffer. Later requests walk the tables again and see the new contents.
- R7: An entry whose present bit is 0 gives rsp_fault=1 and rsp_paddr=0, and it is never cached. Repeating the request takes the miss latency again.
- R8: Rights codes: 00 allows read and write, 01 allows read only, 10 allows execute only, 11 allows read, write or execute only when req_priv=1. Access codes are 00 read, 01 write, 10 execute, and 11, which is always refused. A refused access gives rsp_viol=1 and rsp_paddr=0, and the mapping is still cached.
- R9: rsp_fault and rsp_viol are never both 1. A page that is not present reports only a fault, whatever its rights code.
- R10: The page-table address is (segment base + page) modulo 256.
- R11: Programming port: prog_sel=0 writes segment entry prog_addr[3:0] with base prog_data[7:0]. prog_sel=1 writes page entry prog_addr with prog_data[14]=present, prog_data[13:12]=rights and prog_data[11:0]=block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_laddr | input | 20 | Logical address {segment, page, word} |
| req_acc | input | 2 | Access type code |
| req_priv | input | 1 | Requester is privileged |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_paddr | output | 20 | Physical address {block, word}, zero on error |
| rsp_fault | output | 1 | Page not present |
| rsp_viol | output | 1 | Access refused by rights code |
| prog_en | input | 1 | Table write strobe |
| prog_sel | input | 1 | 0 selects the segment table, 1 selects the page table |
| prog_addr | input | 8 | Table entry index |
| prog_data | input | 15 | Entry contents |

## Verification
A wrong buffer state shows up as a change in latency. A stale or missing entry turns a one-cycle answer into a three-cycle one, or the reverse, and it can also return an outdated block number. A broken replacement pointer evicts the wrong mapping, which shows up only on the request that follows the fifth distinct insertion. A bad table walk shows at the ports three cycles after acceptance, as a wrong block, a missing fault or a flipped violation flag.

// File: rtl/xlate_pkg.sv
`timescale 1ns/1ps
package xlate_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_SEG, ST_PT} walk_state_e;

   localparam logic [1:0] ACC_READ  = 2'b00;
   localparam logic [1:0] ACC_WRITE = 2'b01;
   localparam logic [1:0] ACC_EXEC  = 2'b10;

   localparam logic [1:0] RIGHT_RW   = 2'b00;
   localparam logic [1:0] RIGHT_RO   = 2'b01;
   localparam logic [1:0] RIGHT_XO   = 2'b10;
   localparam logic [1:0] RIGHT_SYS  = 2'b11;
endpackage

// File: rtl/xl_rights.sv
`timescale 1ns/1ps
module xl_rights
   import xlate_pkg::*;
(
   input  logic [1:0] rights,
   input  logic [1:0] acc,
   input  logic       priv,
   output logic       allow
);
   always_comb begin
      unique case (rights)
         RIGHT_RW:  allow = (acc == ACC_READ) || (acc == ACC_WRITE);
         RIGHT_RO:  allow = (acc == ACC_READ);
         RIGHT_XO:  allow = (acc == ACC_EXEC);
         default:   allow = priv && (acc != 2'b11);
      endcase
   end
endmodule

// File: rtl/xl_tables.sv
`timescale 1ns/1ps
module xl_tables #(
   parameter int SEG_W = 4,
   parameter int PT_AW = 8,
   parameter int PTE_W = 15,
   parameter int PD_W  = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [PT_AW-1:0] wr_addr,
   input  logic [PD_W-1:0]  wr_data,
   input  logic [SEG_W-1:0] seg_idx,
   output logic [PT_AW-1:0] seg_base,
   input  logic [PT_AW-1:0] pt_idx,
   output logic [PTE_W-1:0] pte
);
   localparam int SEG_N = 1 << SEG_W;
   localparam int PT_N  = 1 << PT_AW;

   logic [PT_AW-1:0] seg_q [SEG_N];
   logic [PTE_W-1:0] pt_q  [PT_N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SEG_N; i++) seg_q[i] <= '0;
      end else if (wr_en && !wr_sel) begin
         seg_q[wr_addr[SEG_W-1:0]] <= wr_data[PT_AW-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < PT_N; i++) pt_q[i] <= '0;
      end else if (wr_en && wr_sel) begin
         pt_q[wr_addr] <= wr_data[PTE_W-1:0];
      end
   end

   assign seg_base = seg_q[seg_idx];
   assign pte      = pt_q[pt_idx];
endmodule

// File: rtl/xl_tlb.sv
`timescale 1ns/1ps
module xl_tlb #(
   parameter int TAG_W = 12,
   parameter int VAL_W = 14,
   parameter int N     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [TAG_W-1:0] look_tag,
   output logic             hit,
   output logic [VAL_W-1:0] hit_val,
   input  logic             ins,
   input  logic [TAG_W-1:0] ins_tag,
   input  logic [VAL_W-1:0] ins_val
);
   localparam int IW = (N > 1) ? $clog2(N) : 1;

   logic [N-1:0]     vld_q;
   logic [TAG_W-1:0] tag_q [N];
   logic [VAL_W-1:0] val_q [N];
   logic [IW-1:0]    ptr_q;
   logic [N-1:0]     hit_vec;

   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign hit_vec[g] = vld_q[g] && (tag_q[g] == look_tag);
   end

   always_comb begin
      hit_val = '0;
      for (int i = 0; i < N; i++)
         if (hit_vec[i]) hit_val = hit_val | val_q[i];
   end
   assign hit = |hit_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         ptr_q <= '0;
         for (int i = 0; i < N; i++) begin
            tag_q[i] <= '0;
            val_q[i] <= '0;
         end
      end else if (clr) begin
         vld_q <= '0;
         ptr_q <= '0;
      end else if (ins) begin
         vld_q[ptr_q] <= 1'b1;
         tag_q[ptr_q] <= ins_tag;
         val_q[ptr_q] <= ins_val;
         ptr_q <= (ptr_q == IW'(N-1)) ? '0 : ptr_q + 1'b1;
      end
   end

   AST_TLB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)); // R4
   AST_TLB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (vld_q == '0)); // R6
endmodule

// File: rtl/seg_page_xlate.sv
`timescale 1ns/1ps
module seg_page_xlate
   import xlate_pkg::*;
#(
   parameter int SEG_W  = 4,
   parameter int PAGE_W = 8,
   parameter int WORD_W = 8,
   parameter int BLK_W  = 12,
   parameter int PT_AW  = 8,
   parameter int TLB_N  = 4,
   localparam int LA_W  = SEG_W + PAGE_W + WORD_W,
   localparam int PA_W  = BLK_W + WORD_W,
   localparam int PTE_W = BLK_W + 3,
   localparam int PD_W  = (PTE_W > PT_AW) ? PTE_W : PT_AW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [LA_W-1:0]  req_laddr,
   input  logic [1:0]       req_acc,
   input  logic             req_priv,
   output logic             rsp_valid,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic             rsp_fault,
   output logic             rsp_viol,
   input  logic             prog_en,
   input  logic             prog_sel,
   input  logic [PT_AW-1:0] prog_addr,
   input  logic [PD_W-1:0]  prog_data
);
   localparam int VPN_W = SEG_W + PAGE_W;
   localparam int TV_W  = BLK_W + 2;

   if (PT_AW < SEG_W) begin : g_bad_aw
      $error("PT_AW must cover the segment index");
   end
   if (TLB_N > 64) begin : g_bad_n
      $error("TLB_N too large for a fully associative search");
   end

   walk_state_e      state_q;
   logic [VPN_W-1:0] vpn_q;
   logic [WORD_W-1:0] word_q;
   logic [1:0]       acc_q;
   logic             priv_q;
   logic [PT_AW-1:0] pta_q;
   logic             stale_q;

   logic [VPN_W-1:0] req_vpn;
   logic             accept;
   logic             tlb_hit;
   logic [TV_W-1:0]  tlb_val;
   logic             tlb_ins;
   logic [PT_AW-1:0] seg_base;
   logic [PTE_W-1:0] pte;
   logic             hit_ok, walk_ok;
   logic             pte_present;
   logic [1:0]       pte_rights;
   logic [BLK_W-1:0] pte_blk;

   assign req_vpn     = req_laddr[LA_W-1:WORD_W];
   assign req_ready   = (state_q == ST_IDLE);
   assign accept      = req_valid && req_ready;
   assign pte_present = pte[BLK_W+2];
   assign pte_rights  = pte[BLK_W+1:BLK_W];
   assign pte_blk     = pte[BLK_W-1:0];
   assign tlb_ins     = (state_q == ST_PT) && pte_present && !stale_q && !prog_en;

   xl_tables #(.SEG_W(SEG_W), .PT_AW(PT_AW), .PTE_W(PTE_W), .PD_W(PD_W)) tbl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (prog_en),
      .wr_sel   (prog_sel),
      .wr_addr  (prog_addr),
      .wr_data  (prog_data),
      .seg_idx  (vpn_q[VPN_W-1:PAGE_W]),
      .seg_base (seg_base),
      .pt_idx   (pta_q),
      .pte      (pte)
   );

   if (TLB_N > 0) begin : g_tlb
      xl_tlb #(.TAG_W(VPN_W), .VAL_W(TV_W), .N(TLB_N)) tlb_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (prog_en),
         .look_tag (req_vpn),
         .hit      (tlb_hit),
         .hit_val  (tlb_val),
         .ins      (tlb_ins),
         .ins_tag  (vpn_q),
         .ins_val  ({pte_rights, pte_blk})
      );
   end else begin : g_no_tlb
      assign tlb_hit = 1'b0;
      assign tlb_val = '0;
   end

   xl_rights hit_rights_i (
      .rights (tlb_val[TV_W-1:BLK_W]),
      .acc    (req_acc),
      .priv   (req_priv),
      .allow  (hit_ok)
   );

   xl_rights walk_rights_i (
      .rights (pte_rights),
      .acc    (acc_q),
      .priv   (priv_q),
      .allow  (walk_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         vpn_q     <= '0;
         word_q    <= '0;
         acc_q     <= '0;
         priv_q    <= 1'b0;
         pta_q     <= '0;
         stale_q   <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_paddr <= '0;
         rsp_fault <= 1'b0;
         rsp_viol  <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  vpn_q   <= req_vpn;
                  word_q  <= req_laddr[WORD_W-1:0];
                  acc_q   <= req_acc;
                  priv_q  <= req_priv;
                  stale_q <= 1'b0;
                  if (tlb_hit) begin
                     rsp_valid <= 1'b1;
                     rsp_fault <= 1'b0;
                     rsp_viol  <= !hit_ok;
                     rsp_paddr <= hit_ok ? {tlb_val[BLK_W-1:0], req_laddr[WORD_W-1:0]} : '0;
                  end else begin
                     state_q <= ST_SEG;
                  end
               end
            end
            ST_SEG: begin
               pta_q   <= seg_base + PT_AW'(vpn_q[PAGE_W-1:0]);
               state_q <= ST_PT;
               if (prog_en) stale_q <= 1'b1;
            end
            default: begin
               rsp_valid <= 1'b1;
               rsp_fault <= !pte_present;
               rsp_viol  <= pte_present && !walk_ok;
               rsp_paddr <= (pte_present && walk_ok) ? {pte_blk, word_q} : '0;
               state_q   <= ST_IDLE;
            end
         endcase
      end
   end

   AST_RSP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !(rsp_fault && rsp_viol)); // R9
   AST_BAD_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (rsp_fault || rsp_viol)) |-> (rsp_paddr == '0)); // R7
   AST_WORD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault && !rsp_viol) |-> (rsp_paddr[WORD_W-1:0] == word_q)); // R2
   AST_WALK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PT) |-> ($past(state_q) == ST_SEG)); // R3
   AST_SEG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SEG) |-> !rsp_valid); // R3
endmodule

// File: tb/seg_page_xlate_tb_top.sv
`timescale 1ns/1ps
module seg_page_xlate_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [19:0] req_laddr = '0;
   logic [1:0]  req_acc = '0;
   logic        req_priv = 1'b0;
   logic        rsp_valid;
   logic [19:0] rsp_paddr;
   logic        rsp_fault, rsp_viol;
   logic        prog_en = 1'b0;
   logic        prog_sel = 1'b0;
   logic [7:0]  prog_addr = '0;
   logic [14:0] prog_data = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   seg_page_xlate dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
      .req_acc(req_acc), .req_priv(req_priv),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_viol(rsp_viol),
      .prog_en(prog_en), .prog_sel(prog_sel), .prog_addr(prog_addr), .prog_data(prog_data)
   );

   // {laddr, acc, priv, paddr, fault, viol, latency}
   localparam int NV = 17;
   localparam logic [46:0] VEC [NV] = '{
      {20'h6027E, 2'd0, 1'b0, 20'h0197E, 1'b0, 1'b0, 2'd3},  // R2 R3 walk
      {20'h60200, 2'd0, 1'b0, 20'h01900, 1'b0, 1'b0, 2'd1},  // R4 hit
      {20'h600FF, 2'd1, 1'b0, 20'h012FF, 1'b0, 1'b0, 2'd3},  // R8 rw write
      {20'h12055, 2'd0, 1'b0, 20'h4AB55, 1'b0, 1'b0, 2'd3},  // R10 wrap
      {20'h12055, 2'd1, 1'b0, 20'h00000, 1'b0, 1'b1, 2'd1},  // R8 ro write, cached
      {20'h20010, 2'd2, 1'b0, 20'h11110, 1'b0, 1'b0, 2'd3},  // R8 exec only
      {20'h20010, 2'd0, 1'b0, 20'h00000, 1'b0, 1'b1, 2'd1},  // R8 exec only read
      {20'h20120, 2'd0, 1'b0, 20'h00000, 1'b0, 1'b1, 2'd3},  // R8 system, user
      {20'h20120, 2'd1, 1'b1, 20'h22220, 1'b0, 1'b0, 2'd1},  // R8 system, priv
      {20'h20200, 2'd0, 1'b0, 20'h00000, 1'b1, 1'b0, 2'd3},  // R7 R9 fault
      {20'h20200, 2'd0, 1'b0, 20'h00000, 1'b1, 1'b0, 2'd3},  // R7 not cached
      {20'h6027E, 2'd0, 1'b0, 20'h0197E, 1'b0, 1'b0, 2'd3},  // R5 evicted
      {20'h12000, 2'd2, 1'b1, 20'h00000, 1'b0, 1'b1, 2'd1},  // R5 still held
      {20'h60001, 2'd0, 1'b0, 20'h01201, 1'b0, 1'b0, 2'd3},  // R5 evicted
      {20'h60300, 2'd0, 1'b0, 20'h05300, 1'b0, 1'b0, 2'd3},  // R5 walk
      {20'h20100, 2'd0, 1'b1, 20'h22200, 1'b0, 1'b0, 2'd1},  // R5 still held
      {20'h60211, 2'd3, 1'b1, 20'h00000, 1'b0, 1'b1, 2'd1}   // R8 access code 11
   };

   task automatic check_val(input string rq, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic prog(input logic sel, input logic [7:0] addr, input logic [14:0] data);
      @(negedge clk);
      prog_en = 1'b1; prog_sel = sel; prog_addr = addr; prog_data = data;
      @(negedge clk);
      prog_en = 1'b0;
   endtask

   task automatic xlate(input logic [19:0] la, input logic [1:0] acc, input logic priv,
                        output logic [19:0] pa, output logic flt, output logic vio,
                        output int lat, output logic pulse_ok);
      @(negedge clk);
      req_valid = 1'b1; req_laddr = la; req_acc = acc; req_priv = priv;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!rsp_valid && lat < 20) begin
         @(negedge clk);
         lat++;
      end
      pa = rsp_paddr; flt = rsp_fault; vio = rsp_viol;
      @(negedge clk);
      pulse_ok = !rsp_valid && req_ready;
   endtask

   task automatic run_one(input string rq, input logic [19:0] la, input logic [1:0] acc,
                          input logic priv, input logic [19:0] epa, input logic ef,
                          input logic ev, input int elat);
      logic [19:0] pa;
      logic f, v, p;
      int lat;
      xlate(la, acc, priv, pa, f, v, lat, p);
      check_val(rq, "paddr", int'(pa), int'(epa));
      check_val(rq, "fault", int'(f), int'(ev ? 1'b0 : ef));
      check_val(rq, "viol", int'(v), int'(ev));
      check_val(rq, "latency", lat, elat);
      check_val("R3", "single strobe", int'(p), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check_val("R1", "req_ready", int'(req_ready), 1);
      check_val("R1", "rsp_valid", int'(rsp_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_val("R1", "req_ready after release", int'(req_ready), 1);
      run_one("R1", 20'h00000, 2'd0, 1'b0, 20'h0, 1'b1, 1'b0, 3);

      // R11 table loading
      prog(1'b0, 8'h06, 15'h035);
      prog(1'b0, 8'h01, 15'h0F0);
      prog(1'b0, 8'h02, 15'h080);
      prog(1'b1, 8'h35, {1'b1, 2'b00, 12'h012});
      prog(1'b1, 8'h36, {1'b1, 2'b00, 12'h000});
      prog(1'b1, 8'h37, {1'b1, 2'b00, 12'h019});
      prog(1'b1, 8'h38, {1'b1, 2'b00, 12'h053});
      prog(1'b1, 8'h10, {1'b1, 2'b01, 12'h4AB});
      prog(1'b1, 8'h80, {1'b1, 2'b10, 12'h111});
      prog(1'b1, 8'h81, {1'b1, 2'b11, 12'h222});
      prog(1'b1, 8'h82, {1'b0, 2'b11, 12'hABC});

      for (int i = 0; i < NV; i++) begin
         run_one($sformatf("vec%0d", i), VEC[i][46:27], VEC[i][26:25], VEC[i][24],
                 VEC[i][23:4], VEC[i][3], VEC[i][2], int'(VEC[i][1:0]));
      end

      // R6 reprogramming clears the buffer and takes effect
      prog(1'b1, 8'h37, {1'b1, 2'b00, 12'h7FF});
      run_one("R6", 20'h6027E, 2'd0, 1'b0, 20'h7FF7E, 1'b0, 1'b0, 3);
      run_one("R6", 20'h20100, 2'd0, 1'b1, 20'h22200, 1'b0, 1'b0, 3);
      run_one("R4", 20'h20100, 2'd0, 1'b1, 20'h22200, 1'b0, 1'b0, 1);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule